// File: doc/BRIEF.md
# Prescaled Step Machine Timer

This block is a register-mapped machine timer for a single processor. It keeps a free-running 64-bit count. While counting is enabled, the count rises by a programmable step on one clock edge out of every prescale+1. Adding a step other than one lets a fractional ratio between the input clock and the wanted time base be matched exactly. For example, a step of 3 with a prescale of 4 advances the count at 3/5 of the clock rate. Software loads and reads the count as two 32-bit words. It normally stops the count before loading it.

A set of comparators, two by default, each holds a 64-bit threshold. In every cycle where the count is at or beyond a comparator's threshold, that comparator's sticky interrupt-state bit is set. Software clears the bit by writing a one to it. An interrupt-enable bit masks each state bit onto its own interrupt output.

Software reaches every register through a 32-bit request/response port with valid/ready handshakes. A request is taken on a cycle where `req_valid` and `req_ready` are both high. A write takes effect on that edge and returns no response. A read returns its data on `rsp_valid` from the next cycle. When `rsp_ready` is low, that data is held, and `req_ready` stays low until the response is taken. Back-pressure therefore stalls only new requests.

Top module: `step_mtimer`

## Requirements
- R1: After reset, the following read as zero: control, configuration, both count words, interrupt enable and interrupt state. Every threshold word reads 0xFFFFFFFF, and `irq_o` is zero.
- R2: While enabled, the count gains `step` on every (prescale+1)-th clock edge. After N edges of counting from a disabled state, it has gained step*floor(N/(prescale+1)). The configuration word at offset 0x0C holds prescale in bits [11:0] and step in bits [23:16].
- R3: Counting is enabled by bit 0 of the control word at offset 0x00. While that bit is clear, the count holds its value. The prescale phase also returns to zero, so each enabled stretch starts a fresh prescale period.
- R4: The count's low word is at offset 0x04 and its high word at 0x08. Each word is read and written on its own, and an increment carries from the low word into the high word.
- R5: A write to a count word in the same cycle as an increment replaces that word, and the increment is dropped.
- R6: The threshold of comparator k has its low word at offset 0x10+8k and its high word at 0x14+8k. Both words are readable and writable.
- R7: Bit k of the interrupt-state word becomes 1 one edge after any cycle in which the unsigned 64-bit count is greater than or equal to threshold k. The interrupt-state word sits at offset 0x10+8*NUM_CMP+4, which is 0x24 by default.
- R8: Writing 1 to a bit of the interrupt-state word clears that bit, unless its compare condition still holds. Zero bits in the write leave the state unchanged, and a set bit stays set after the condition goes away.
- R9: `irq_o[k]` is 1 exactly when interrupt-state bit k and interrupt-enable bit k are both 1. The enable word sits at offset 0x10+8*NUM_CMP, which is 0x20 by default.
- R10: A request is accepted when `req_valid && req_ready`, where `req_ready = !rsp_valid || rsp_ready`. A read's data appears with `rsp_valid` on the next cycle and is held unchanged while `rsp_ready` is low.
- R11: A read from an unmapped offset returns zero. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | NUM_CMP | One masked interrupt per comparator |

## Verification
The assertions assume the following about the inputs:
- The request fields hold steady only while a request is offered.
- The prescale value is not lowered below the running phase while counting.
- The count and threshold words change only through accepted writes.

The stimulus keeps within these limits:
- It changes configuration only while counting is stopped.
- It drives every request between clock edges.
- It holds `rsp_ready` high except in one back-pressure sequence, where a second request is kept waiting until the first response is taken.

// File: rtl/step_mtimer_pkg.sv
package step_mtimer_pkg;
  // Register offsets that the block decodes.
  localparam int OFF_CTRL    = 'h00;
  localparam int OFF_CNT_LO  = 'h04;
  localparam int OFF_CNT_HI  = 'h08;
  localparam int OFF_CFG     = 'h0C;
  localparam int OFF_CMP0    = 'h10;
  localparam int CMP_STRIDE  = 8;
  localparam int CNT_W       = 64;
  localparam int WORD_W      = 32;

  typedef struct packed {
    logic                wr_lo;
    logic                wr_hi;
    logic [WORD_W-1:0]   data;
  } word_wr_t;
endpackage

// File: rtl/step_mtimer_prescaler.sv
module step_mtimer_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  // The >= keeps a lowered prescale from wrapping the phase around.
  assign tick = en && (phase_q >= prescale);

  always_ff @(posedge clk) begin
    if (!rst_n)             phase_q <= '0;
    else if (!en || tick)   phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  // R3: a disabled timer always restarts its prescale period from zero
  a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase_q == '0));
endmodule

// File: rtl/step_mtimer_count.sv
module step_mtimer_count
  import step_mtimer_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  word_wr_t          wr,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr.wr_lo || wr.wr_hi) begin
      if (wr.wr_lo) cnt_q[WORD_W-1:0]     <= wr.data;
      if (wr.wr_hi) cnt_q[CNT_W-1:WORD_W] <= wr.data;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(step);
    end
  end

  assign count = cnt_q;

  // R5: a software write wins over the increment
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr.wr_lo |=> (cnt_q[WORD_W-1:0] == $past(wr.data)));
  // R2: each tick adds exactly one step
  a_r2_step_add: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr.wr_lo && !wr.wr_hi) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(step))));
  // R3: no tick and no write leaves the count untouched
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr.wr_lo && !wr.wr_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/step_mtimer_cmp.sv
module step_mtimer_cmp
  import step_mtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  word_wr_t          wr,
  input  logic              clr,
  output logic [CNT_W-1:0]  thr,
  output logic              pend
);
  logic [CNT_W-1:0] thr_q;
  logic             pend_q;
  logic             hit;

  assign hit = (count >= thr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '1;
    end else begin
      if (wr.wr_lo) thr_q[WORD_W-1:0]     <= wr.data;
      if (wr.wr_hi) thr_q[CNT_W-1:WORD_W] <= wr.data;
    end
  end

  // Setting has priority over a write-one clear.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q && !clr) || hit;
  end

  assign thr  = thr_q;
  assign pend = pend_q;

  // R7: a reached threshold raises the state bit on the next edge
  a_r7_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);
  // R8: only a clear can drop the state bit
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);
endmodule

// File: rtl/step_mtimer.sv
module step_mtimer
  import step_mtimer_pkg::*;
#(
  parameter int NUM_CMP  = 2,
  parameter int PRE_W    = 12,
  parameter int STEP_W   = 8,
  parameter int STEP_LSB = 16,
  parameter int ADDR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CMP-1:0] irq_o
);
  localparam int OFF_IE = OFF_CMP0 + CMP_STRIDE * NUM_CMP;
  localparam int OFF_IS = OFF_IE + 4;

  logic               accept, do_wr, do_rd;
  logic               en_q;
  logic [PRE_W-1:0]   pre_q;
  logic [STEP_W-1:0]  step_q;
  logic [NUM_CMP-1:0] ie_q;
  logic [NUM_CMP-1:0] pend;
  logic [NUM_CMP-1:0] clr;
  logic               tick;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   thr [NUM_CMP];
  word_wr_t           cnt_wr;
  logic [31:0]        rd_mux;
  logic               rsp_valid_q;
  logic [31:0]        rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign do_wr     = accept && req_write;
  assign do_rd     = accept && !req_write;

  function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  // Control, configuration and interrupt-enable registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      step_q <= '0;
      ie_q   <= '0;
    end else if (do_wr) begin
      if (hit_addr(req_addr, OFF_CTRL)) en_q <= req_wdata[0];
      if (hit_addr(req_addr, OFF_CFG)) begin
        pre_q  <= req_wdata[PRE_W-1:0];
        step_q <= req_wdata[STEP_LSB +: STEP_W];
      end
      if (hit_addr(req_addr, OFF_IE)) ie_q <= req_wdata[NUM_CMP-1:0];
    end
  end

  assign cnt_wr.wr_lo = do_wr && hit_addr(req_addr, OFF_CNT_LO);
  assign cnt_wr.wr_hi = do_wr && hit_addr(req_addr, OFF_CNT_HI);
  assign cnt_wr.data  = req_wdata;
  assign clr = (do_wr && hit_addr(req_addr, OFF_IS)) ? req_wdata[NUM_CMP-1:0] : '0;

  step_mtimer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en_q), .prescale(pre_q), .tick(tick)
  );

  step_mtimer_count #(.STEP_W(STEP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step_q), .wr(cnt_wr), .count(count)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    word_wr_t thr_wr;
    assign thr_wr.wr_lo = do_wr && hit_addr(req_addr, OFF_CMP0 + CMP_STRIDE * k);
    assign thr_wr.wr_hi = do_wr && hit_addr(req_addr, OFF_CMP0 + CMP_STRIDE * k + 4);
    assign thr_wr.data  = req_wdata;

    step_mtimer_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .count(count), .wr(thr_wr),
      .clr(clr[k]), .thr(thr[k]), .pend(pend[k])
    );
  end

  assign irq_o = pend & ie_q;

  // Read multiplexer; unmapped offsets return zero
  always_comb begin
    rd_mux = '0;
    if (hit_addr(req_addr, OFF_CTRL))   rd_mux[0] = en_q;
    if (hit_addr(req_addr, OFF_CFG)) begin
      rd_mux[PRE_W-1:0]          = pre_q;
      rd_mux[STEP_LSB +: STEP_W] = step_q;
    end
    if (hit_addr(req_addr, OFF_CNT_LO)) rd_mux = count[WORD_W-1:0];
    if (hit_addr(req_addr, OFF_CNT_HI)) rd_mux = count[CNT_W-1:WORD_W];
    for (int k = 0; k < NUM_CMP; k++) begin
      if (hit_addr(req_addr, OFF_CMP0 + CMP_STRIDE * k))     rd_mux = thr[k][WORD_W-1:0];
      if (hit_addr(req_addr, OFF_CMP0 + CMP_STRIDE * k + 4)) rd_mux = thr[k][CNT_W-1:WORD_W];
    end
    if (hit_addr(req_addr, OFF_IE)) rd_mux[NUM_CMP-1:0] = ie_q;
    if (hit_addr(req_addr, OFF_IS)) rd_mux[NUM_CMP-1:0] = pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (do_rd) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  // R10: a stalled response keeps its data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R10: a response appears only after an accepted read
  a_r10_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && !req_write));
endmodule

// File: tb/step_mtimer_bench.sv
module step_mtimer_bench;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic [NC-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  step_mtimer u_step_mtimer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  // Vector table: prescale, step, idle gap, expected count
  localparam int NV = 6;
  localparam int VP [NV] = '{0, 0, 2, 4, 1, 9};
  localparam int VS [NV] = '{1, 3, 1, 7, 255, 2};
  localparam int VG [NV] = '{9, 4, 11, 13, 6, 28};
  localparam int VE [NV] = '{10, 15, 4, 14, 765, 4};

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int edge_i);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    edge_i = cyc;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wrq(input logic [7:0] a, input logic [31:0] d);
    int e;
    wr(a, d, e);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int ea, eb, e1, e2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 irq", irq_o, 0);
    rd('h00, d); chk("R1 ctrl", d, 0);
    rd('h0C, d); chk("R1 cfg", d, 0);
    rd('h04, d); chk("R1 cnt lo", d, 0);
    rd('h08, d); chk("R1 cnt hi", d, 0);
    rd('h10, d); chk("R1 cmp0 lo", d, 32'hFFFFFFFF);
    rd('h1C, d); chk("R1 cmp1 hi", d, 32'hFFFFFFFF);
    rd('h20, d); chk("R1 ie", d, 0);
    rd('h24, d); chk("R1 is", d, 0);

    // R2 table of rates
    for (int i = 0; i < NV; i++) begin
      wrq('h04, 0); wrq('h08, 0);
      wrq('h0C, (VS[i] << 16) | VP[i]);
      rd('h0C, d); chk("R2 cfg readback", d, (VS[i] << 16) | VP[i]);
      wr('h00, 1, ea);
      idle(VG[i]);
      wr('h00, 0, eb);
      rd('h04, d); chk("R2 count lo", d, VE[i]);
      rd('h08, d); chk("R2 count hi", d, 0);
    end

    // R3 hold while disabled and prescale restart
    wrq('h04, 0); wrq('h08, 0); wrq('h0C, (1 << 16) | 3);
    wrq('h00, 1); idle(1); wrq('h00, 0);
    wrq('h00, 1); idle(1); wrq('h00, 0);
    rd('h04, d); chk("R3 prescale restart", d, 0);
    wrq('h04, 32'h77); idle(10);
    rd('h04, d); chk("R3 hold while off", d, 32'h77);

    // R4 carry into upper word, words read alone
    wrq('h0C, 1 << 16);
    wrq('h04, 32'hFFFFFFFE); wrq('h08, 5);
    wr('h00, 1, ea); idle(2); wr('h00, 0, eb);
    rd('h08, d); chk("R4 hi after carry", d, 6);
    rd('h04, d); chk("R4 lo after carry", d, 1);

    // R5 write beats increment
    wrq('h04, 0); wrq('h08, 0);
    wr('h00, 1, ea); wr('h04, 32'h100, e1); idle(3); wr('h00, 0, eb);
    rd('h04, d); chk("R5 write priority", d, 32'h100 + (eb - e1));

    // R6/R7/R8/R9 comparators
    wrq('h04, 0); wrq('h08, 0);
    wrq('h14, 0); wrq('h10, 32'h50);
    wrq('h18, 0); wrq('h1C, 1);
    rd('h18, d); chk("R6 cmp1 lo", d, 0);
    rd('h1C, d); chk("R6 cmp1 hi", d, 1);
    idle(2); wrq('h24, 3); idle(2);
    rd('h24, d); chk("R7 below threshold", d, 0);
    wrq('h04, 32'h50); idle(2);
    rd('h24, d); chk("R7 equal sets", d, 1);
    chk("R9 masked", irq_o, 0);
    wrq('h20, 1); idle(1);
    chk("R9 enabled irq", irq_o, 2'b01);
    wrq('h24, 1); idle(2);
    rd('h24, d); chk("R8 set wins over clear", d, 1);
    wrq('h04, 32'h10); wrq('h24, 0); idle(2);
    rd('h24, d); chk("R8 sticky and zero write", d, 1);
    wrq('h24, 1); idle(2);
    rd('h24, d); chk("R8 cleared", d, 0);
    chk("R9 irq low after clear", irq_o, 0);
    wrq('h04, 32'h60); idle(2);
    rd('h24, d); chk("R7 passed sets", d, 1);
    wrq('h04, 32'hFFFFFFFF); wrq('h24, 3); idle(2);
    rd('h24, d); chk("R7 64-bit upper decides", d, 1);
    wrq('h08, 1); wrq('h04, 0); idle(2);
    wrq('h20, 3); idle(1);
    chk("R9 both irqs", irq_o, 2'b11);
    rd('h24, d); chk("R7 cmp1 set", d, 3);

    // R11 unmapped
    wrq('h30, 32'hFFFFFFFF); wrq('h0E, 32'hFFFFFFFF);
    rd('h30, d); chk("R11 unmapped read", d, 0);
    rd('h0C, d); chk("R11 cfg untouched", d, 1 << 16);

    // R10 back-pressure
    wrq('h08, 32'hA5); wrq('h04, 32'h5A);
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 'h08;
    @(posedge clk); #1;
    req_addr = 'h04;
    idle(3);
    chk("R10 ready low", req_ready, 0);
    chk("R10 rsp held valid", rsp_valid, 1);
    chk("R10 rsp held data", rsp_rdata, 32'hA5);
    @(negedge clk); rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R10 second read", rsp_rdata, 32'h5A);
    idle(1);
    chk("R10 rsp drained", rsp_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule